// File: doc/BRIEF.md
# Shared-Drive Attach and Isolation Controller

This block sits between a USB mass-storage bridge and an ATA/IDE drive that is also wired to an external media-player processor. It decides, cycle by cycle, whether the bridge may drive the IDE bus or must leave every IDE pad in high impedance so the other processor can use the drive. The decision comes from three status signals: a VBUS/enable line, which the external processor can pull low to force a detach; a host-suspend status, which covers both USB suspend and a safe removal by the host; and an enumeration-done status.

The controller is a five-state machine. ST_UNPOWERED is the state after reset and is held until VBUS/enable has first been seen high. ST_ENUM waits for enumeration to complete. ST_NORMAL is the only state in which the IDE pads are enabled. ST_SUSPENDED releases the bus and raises an active-high suspend indicator. ST_DETACHED is entered whenever VBUS/enable drops after it has once been high. The named transitions are: power-up (UNPOWERED to ENUM on VBUS high), re-attach (DETACHED to ENUM on VBUS high), enumerated (ENUM to NORMAL on enum-done), suspend (NORMAL to SUSPENDED on host-suspend), resume (SUSPENDED to NORMAL on a resume event while host-suspend is low), and detach (any state except UNPOWERED to DETACHED on VBUS low). Detach takes priority over every other transition. On the first entry to ST_NORMAL after a detach, the block pulses a drive-reset output for a set number of cycles. It also captures the boot-ROM select strap as reset is released.

Top module: `drive_share_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, the state is ST_UNPOWERED and ide_oe_o, susp_ind_o and drv_rst_o are all 0.
- R2: vbus_en_i passes through a two-flop synchronizer. If it falls while the bus is driven, ide_oe_o is still 1 after the second rising clock edge and is 0 after the third. From then on it stays 0 while vbus_en_i is low, in every state.
- R3: ide_oe_o is 1 only in ST_NORMAL. It is never 1 together with susp_ind_o.
- R4: In ST_NORMAL, a host_susp_i high at a clock edge moves the block to ST_SUSPENDED. After that edge ide_oe_o is 0 and susp_ind_o is 1.
- R5: ST_SUSPENDED is left for ST_NORMAL only on an edge where resume_i is 1 and host_susp_i is 0. Otherwise susp_ind_o stays 1 while VBUS stays high.
- R6: ST_ENUM moves to ST_NORMAL on an edge where enum_done_i is 1. It ignores host_susp_i and resume_i. ST_UNPOWERED ignores enum_done_i while VBUS is low.
- R7: On the first entry to ST_NORMAL after a pass through ST_DETACHED, drv_rst_o is 1 for exactly RST_CYCLES cycles, starting in the cycle ST_NORMAL is entered. There is no pulse on the power-up entry or on a resume. drv_rst_o is never 1 outside ST_NORMAL.
- R8: int_rom_sel_o holds the value rom_strap_i had at the last clock edge before rst_n rose (1 selects internal ROM). Changes to rom_strap_i after reset release have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vbus_en_i | input | 1 | Asynchronous VBUS/enable; low forces detach |
| host_susp_i | input | 1 | Host suspended or safe removal done |
| resume_i | input | 1 | Resume event from the USB core |
| enum_done_i | input | 1 | Enumeration complete |
| rom_strap_i | input | 1 | Boot-ROM select strap (1 = internal ROM) |
| ide_oe_o | output | 1 | Output enable for all IDE pads |
| susp_ind_o | output | 1 | Active-high suspend indicator |
| drv_rst_o | output | 1 | Active-high ATA drive reset |
| int_rom_sel_o | output | 1 | Latched internal-ROM select |

## Verification
Each of ST_ENUM, ST_NORMAL and ST_SUSPENDED is driven into, and then given a one-cycle pulse of every combination of host_susp_i, resume_i and enum_done_i. An arithmetic model of the transitions predicts the resulting pad-enable and indicator values. This separates the inputs each state must react to from the ones it must ignore, including the case where resume and suspend are both high. Separate runs pull VBUS low from each state and measure the two-edge synchronizer latency. A drive-reset pulse is counted on the power-up, re-attach and resume entries, which tells apart the one entry that must pulse from the two that must not. Two reset cycles with opposite strap values, followed by strap toggles, show that the latched value changes only at reset release.

// File: rtl/drive_share_pkg.sv
package drive_share_pkg;
    typedef enum logic [2:0] {
        ST_UNPOWERED = 3'd0,
        ST_ENUM      = 3'd1,
        ST_NORMAL    = 3'd2,
        ST_SUSPENDED = 3'd3,
        ST_DETACHED  = 3'd4
    } attach_state_t;
endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ds_attach_fsm.sv
module ds_attach_fsm
    import drive_share_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vbus_s,
    input  logic          host_susp,
    input  logic          resume,
    input  logic          enum_done,
    output attach_state_t state_o,
    output logic          norm_next_o,
    output logic          enter_norm_o,
    output logic          ide_oe,
    output logic          susp_ind
);
    attach_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!vbus_s) begin
            state_d = (state_q == ST_UNPOWERED) ? ST_UNPOWERED : ST_DETACHED;
        end else begin
            unique case (state_q)
                ST_UNPOWERED: state_d = ST_ENUM;
                ST_DETACHED:  state_d = ST_ENUM;
                ST_ENUM:      if (enum_done) state_d = ST_NORMAL;
                ST_NORMAL:    if (host_susp) state_d = ST_SUSPENDED;
                ST_SUSPENDED: if (resume && !host_susp) state_d = ST_NORMAL;
                default:      state_d = ST_UNPOWERED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNPOWERED;
        else        state_q <= state_d;
    end

    always_comb begin
        ide_oe   = 1'b0;
        susp_ind = 1'b0;
        unique case (state_q)
            ST_NORMAL:    ide_oe   = 1'b1;
            ST_SUSPENDED: susp_ind = 1'b1;
            default: ;
        endcase
    end

    assign state_o      = state_q;
    assign norm_next_o  = (state_d == ST_NORMAL);
    assign enter_norm_o = (state_q == ST_ENUM) && (state_d == ST_NORMAL);
endmodule

// File: rtl/ds_reset_pulse.sv
module ds_reset_pulse #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_detached,
    input  logic enter_norm,
    input  logic norm_next,
    output logic drv_rst
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic          pending_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            if (in_detached)                   pending_q <= 1'b1;
            else if (enter_norm && pending_q)  pending_q <= 1'b0;

            if (!norm_next)                    cnt_q <= '0;
            else if (enter_norm && pending_q)  cnt_q <= LOAD;
            else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
        end
    end

    assign drv_rst = (cnt_q != '0);
endmodule

// File: rtl/drive_share_ctrl.sv
module drive_share_ctrl
    import drive_share_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vbus_en_i,
    input  logic host_susp_i,
    input  logic resume_i,
    input  logic enum_done_i,
    input  logic rom_strap_i,
    output logic ide_oe_o,
    output logic susp_ind_o,
    output logic drv_rst_o,
    output logic int_rom_sel_o
);
    logic          vbus_s;
    attach_state_t state;
    logic          norm_next, enter_norm;
    logic          strap_q;

    ds_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (vbus_en_i),
        .sync_o  (vbus_s)
    );

    ds_attach_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .vbus_s       (vbus_s),
        .host_susp    (host_susp_i),
        .resume       (resume_i),
        .enum_done    (enum_done_i),
        .state_o      (state),
        .norm_next_o  (norm_next),
        .enter_norm_o (enter_norm),
        .ide_oe       (ide_oe_o),
        .susp_ind     (susp_ind_o)
    );

    ds_reset_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_detached (state == ST_DETACHED),
        .enter_norm  (enter_norm),
        .norm_next   (norm_next),
        .drv_rst     (drv_rst_o)
    );

    // Strap follows the pin while reset is held and freezes on release.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= rom_strap_i;
    end

    assign int_rom_sel_o = strap_q;
endmodule

// File: rtl/drive_share_chk.sv
module drive_share_chk (
    input logic clk,
    input logic rst_n,
    input logic vbus_s,
    input logic host_susp_i,
    input logic resume_i,
    input logic ide_oe_o,
    input logic susp_ind_o,
    input logic drv_rst_o,
    input logic int_rom_sel_o
);
    // R2
    vbus_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_s |=> !ide_oe_o);

    // R3
    oe_ind_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ide_oe_o && susp_ind_o));

    // R4
    suspend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_oe_o && host_susp_i) |=> (!ide_oe_o));

    // R5
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_ind_o && vbus_s && (host_susp_i || !resume_i)) |=> susp_ind_o);

    // R7
    drv_rst_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_rst_o |-> ide_oe_o);

    // R8
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(int_rom_sel_o));
endmodule

bind drive_share_ctrl drive_share_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vbus_s        (vbus_s),
    .host_susp_i   (host_susp_i),
    .resume_i      (resume_i),
    .ide_oe_o      (ide_oe_o),
    .susp_ind_o    (susp_ind_o),
    .drv_rst_o     (drv_rst_o),
    .int_rom_sel_o (int_rom_sel_o)
);

// File: tb/drive_share_ctrl_test.sv
`timescale 1ns/1ps
module drive_share_ctrl_test;
    localparam int NRST = 5;
    localparam int S_ENUM = 1, S_NORM = 2, S_SUSP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vbus = 1'b0, susp = 1'b0, res = 1'b0, edone = 1'b0, strap = 1'b0;
    logic oe, ind, drst, romsel;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    drive_share_ctrl #(.SYNC_STAGES(2), .RST_CYCLES(NRST)) uut (
        .clk(clk), .rst_n(rst_n), .vbus_en_i(vbus), .host_susp_i(susp),
        .resume_i(res), .enum_done_i(edone), .rom_strap_i(strap),
        .ide_oe_o(oe), .susp_ind_o(ind), .drv_rst_o(drst), .int_rom_sel_o(romsel)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts drive-reset cycles over a window after a one-cycle enum_done pulse.
    task automatic enter_normal(output int pulses);
        pulses = 0;
        @(negedge clk); edone = 1'b1;
        @(negedge clk); edone = 1'b0;
        for (int i = 0; i < NRST + 6; i++) begin
            if (drst) pulses++;
            @(negedge clk);
        end
    endtask

    task automatic go_enum;
        vbus = 1'b0; cyc(4);
        vbus = 1'b1; cyc(4);
    endtask

    task automatic go_state(input int s);
        int p;
        go_enum();
        if (s >= S_NORM) enter_normal(p);
        if (s == S_SUSP) begin
            susp = 1'b1; cyc(1); susp = 1'b0; cyc(1);
        end
    endtask

    function automatic int model_next(input int s, input bit sp, input bit rs, input bit ed);
        case (s)
            S_ENUM:  return ed ? S_NORM : S_ENUM;
            S_NORM:  return sp ? S_SUSP : S_NORM;
            default: return (rs && !sp) ? S_NORM : S_SUSP;
        endcase
    endfunction

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int p;
        int exp_s;
        strap = 1'b0;
        cyc(3);
        // R1 reset state
        check("R1 oe in reset", oe, 0);
        check("R1 ind in reset", ind, 0);
        check("R1 drst in reset", drst, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after release", oe, 0);
        check("R1 ind after release", ind, 0);
        // R8 strap latched low, later toggles ignored
        check("R8 strap low latched", romsel, 0);
        strap = 1'b1; cyc(3);
        check("R8 strap change ignored", romsel, 0);

        // R6 unpowered ignores enum_done
        edone = 1'b1; cyc(3); edone = 1'b0;
        check("R6 unpowered ignores enum_done", oe, 0);

        // R7 power-up entry: no drive reset
        vbus = 1'b1; cyc(4);
        enter_normal(p);
        check("R7 no pulse at power-up", p, 0);
        check("R3 oe in normal", oe, 1);

        // R2 synchronizer latency
        vbus = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R2 oe after two edges", oe, 1);
        @(posedge clk); #1;
        check("R2 oe after three edges", oe, 0);
        cyc(3);
        check("R2 oe while vbus low", oe, 0);

        // R7 re-attach entry pulses NRST cycles
        vbus = 1'b1; cyc(4);
        enter_normal(p);
        check("R7 pulse after detach", p, NRST);
        enter_normal(p);
        check("R7 no pulse on repeat enum_done", p, 0);

        // R7 resume entry: no pulse
        susp = 1'b1; cyc(1); susp = 1'b0; cyc(1);
        check("R4 indicator in suspend", ind, 1);
        check("R4 oe in suspend", oe, 0);
        res = 1'b1; cyc(1); res = 1'b0;
        p = 0;
        for (int i = 0; i < NRST + 4; i++) begin
            if (drst) p++;
            @(negedge clk);
        end
        check("R7 no pulse on resume", p, 0);
        check("R5 resume returns to normal", oe, 1);

        // R3 R4 R5 R6 sweep: every pulse combination from each state
        for (int s = S_ENUM; s <= S_SUSP; s++) begin
            for (int c = 0; c < 8; c++) begin
                go_state(s);
                @(negedge clk);
                susp = c[0]; res = c[1]; edone = c[2];
                @(negedge clk);
                exp_s = model_next(s, c[0], c[1], c[2]);
                check((s == S_ENUM) ? "R6 sweep oe" : (s == S_NORM) ? "R4 sweep oe" : "R5 sweep oe",
                      oe, (exp_s == S_NORM) ? 1 : 0);
                check("R3 sweep ind", ind, (exp_s == S_SUSP) ? 1 : 0);
                susp = 1'b0; res = 1'b0; edone = 1'b0;
                cyc(1);
            end
        end

        // R2 vbus drop from suspended clears indicator and keeps bus off
        go_state(S_SUSP);
        vbus = 1'b0; cyc(4);
        check("R2 detach from suspend ind", ind, 0);
        check("R2 detach from suspend oe", oe, 0);

        // R8 second reset with strap high
        rst_n = 1'b0; strap = 1'b1; cyc(3);
        rst_n = 1'b1; cyc(1);
        strap = 1'b0; cyc(3);
        check("R8 strap high latched", romsel, 1);
        check("R1 oe after second reset", oe, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule